// File: doc/BRIEF.md
# Cascaded One-Pole Decimating Low-Pass Filter

This block turns a stream of signed samples arriving at a high, irregular rate into a slower, wider stream. It suits audio-rate control values taken from a fast measurement front end. A chain of identical first-order recursive low-pass sections removes the content that would alias. A decimator then emits one filtered value each time an output tick arrives. In the intended setting the ticks come at 48 kHz, and the chain is tuned for a combined -3 dB corner near 416 Hz. At that setting about 112 dB of rejection remains at 24 kHz, which is roughly 18 bits of clean margin.

Each section moves its state a power-of-two fraction of the way toward its input: `y <= y + ((x - y) >>> SHIFT)`. Recent input therefore carries more weight than older input. The block needs no multipliers and keeps no sample history. The states carry `GUARD_W` fractional bits below the input LSB, so small steps are not lost. Sections are registered, so section n reads the state that section n-1 held before the current update. All sections update together, and only on a valid input sample.

Top module: `lpf_decim`

## Requirements
- R1: While `rst_ni` is low, every section state, `out_data_o` and `out_valid_o` are zero. A tick with no prior input therefore emits 0.
- R2: On every cycle with `in_valid_i` high, each section n updates to `y_n + ((x_n - y_n) >>> SHIFT)`, using arithmetic shift with floor rounding. Section 0 takes `x_0 = in_data_i * 2^GUARD_W`. Section n>0 takes `x_n` equal to section n-1's state before this update.
- R3: Section states and `out_data_o` always stay within [-2^(IN_W-1)*2^GUARD_W, (2^(IN_W-1)-1)*2^GUARD_W]. Full-scale steps in either direction cause no wrap-around.
- R4: On cycles with `in_valid_i` low, no section state changes. Ticks taken during such idle stretches emit the same value again.
- R5: A cycle with `tick_i` high is followed by exactly one cycle with `out_valid_o` high. In that cycle `out_data_o` equals the last section's state as it stood at the tick edge.
- R6: `out_valid_o` is low in every cycle that does not follow a tick. `out_data_o` holds its value between ticks.
- R7: When `tick_i` and `in_valid_i` are high in the same cycle, the output carries the last section's pre-update state, and the sections still take the new sample.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk_i | input | 1 | Clock |
| rst_ni | input | 1 | Asynchronous active-low reset |
| in_valid_i | input | 1 | Input sample strobe |
| in_data_i | input | IN_W | Signed input sample |
| tick_i | input | 1 | Output-rate tick, one cycle per output |
| out_valid_o | output | 1 | Output strobe, one cycle per tick |
| out_data_o | output | IN_W+GUARD_W | Signed filtered output with GUARD_W fractional bits |

## Verification
The two functions that can meet in one cycle are the section update on an input sample and the decimator capture on a tick. The bench provokes this with a directed stretch where both strobes are high on every cycle, and with random stretches where each strobe is drawn independently. A bench model samples its own last-section value before applying the update, and each emitted value must equal that pre-update value. A capture that saw the post-update state would differ by the latest step and fail the check.

// File: rtl/lpf_decim_pkg.sv
package lpf_decim_pkg;
  function automatic int state_width(input int in_w, input int guard_w);
    return in_w + guard_w;
  endfunction
endpackage

// File: rtl/lpf_stage.sv
module lpf_stage #(
  parameter int STATE_W = 24,
  parameter int SHIFT   = 4
) (
  input  logic               clk_i,
  input  logic               rst_ni,
  input  logic               en_i,
  input  logic [STATE_W-1:0] x_i,
  output logic [STATE_W-1:0] y_o
);
  localparam int EXT_W = STATE_W + 1;

  logic [STATE_W-1:0] y_q;
  logic signed [EXT_W-1:0] diff, step, sum;

  // one extra bit keeps x - y from wrapping on full-scale swings
  always_comb begin
    diff = $signed({x_i[STATE_W-1], x_i}) - $signed({y_q[STATE_W-1], y_q});
    step = diff >>> SHIFT;
    sum  = $signed({y_q[STATE_W-1], y_q}) + step;
  end

  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni)   y_q <= '0;
    else if (en_i) y_q <= sum[STATE_W-1:0];
  end

  assign y_o = y_q;
endmodule

// File: rtl/lpf_decimator.sv
module lpf_decimator #(
  parameter int W = 24
) (
  input  logic         clk_i,
  input  logic         rst_ni,
  input  logic         tick_i,
  input  logic [W-1:0] d_i,
  output logic         valid_o,
  output logic [W-1:0] q_o
);
  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni) begin
      valid_o <= 1'b0;
      q_o     <= '0;
    end else begin
      valid_o <= tick_i;
      if (tick_i) q_o <= d_i;
    end
  end
endmodule

// File: rtl/lpf_decim.sv
module lpf_decim #(
  parameter int IN_W    = 16,
  parameter int GUARD_W = 8,
  parameter int SHIFT   = 4,
  parameter int STAGES  = 4
) (
  input  logic                    clk_i,
  input  logic                    rst_ni,
  input  logic                    in_valid_i,
  input  logic [IN_W-1:0]         in_data_i,
  input  logic                    tick_i,
  output logic                    out_valid_o,
  output logic [IN_W+GUARD_W-1:0] out_data_o
);
  localparam int STATE_W = lpf_decim_pkg::state_width(IN_W, GUARD_W);

  logic [STATE_W-1:0] tap [STAGES+1];
  logic [STATE_W-1:0] tail_w;

  assign tap[0] = {in_data_i, {GUARD_W{1'b0}}};

  for (genvar s = 0; s < STAGES; s++) begin : g_stage
    lpf_stage #(.STATE_W(STATE_W), .SHIFT(SHIFT)) u_stage (
      .clk_i (clk_i),
      .rst_ni(rst_ni),
      .en_i  (in_valid_i),
      .x_i   (tap[s]),
      .y_o   (tap[s+1])
    );
  end

  assign tail_w = tap[STAGES];

  lpf_decimator #(.W(STATE_W)) u_decim (
    .clk_i  (clk_i),
    .rst_ni (rst_ni),
    .tick_i (tick_i),
    .d_i    (tail_w),
    .valid_o(out_valid_o),
    .q_o    (out_data_o)
  );
endmodule

// File: rtl/lpf_decim_chk.sv
module lpf_decim_chk #(
  parameter int IN_W    = 16,
  parameter int GUARD_W = 8
) (
  input logic                    clk_i,
  input logic                    rst_ni,
  input logic                    in_valid_i,
  input logic                    tick_i,
  input logic                    out_valid_o,
  input logic [IN_W+GUARD_W-1:0] out_data_o,
  input logic [IN_W+GUARD_W-1:0] tail_i
);
  localparam int W = IN_W + GUARD_W;
  localparam logic [W-1:0] HI = {1'b0, {(IN_W-1){1'b1}}, {GUARD_W{1'b0}}};
  localparam logic [W-1:0] LO = {1'b1, {(W-1){1'b0}}};

  a_r1_reset_quiet: assert property (@(posedge clk_i)
    !rst_ni |=> (!rst_ni && !out_valid_o && out_data_o == '0) || rst_ni);

  a_r3_no_overflow: assert property (@(posedge clk_i) disable iff (!rst_ni)
    $signed(tail_i) <= $signed(HI) && $signed(tail_i) >= $signed(LO));

  a_r3_out_in_range: assert property (@(posedge clk_i) disable iff (!rst_ni)
    $signed(out_data_o) <= $signed(HI) && $signed(out_data_o) >= $signed(LO));

  a_r4_hold_when_idle: assert property (@(posedge clk_i) disable iff (!rst_ni)
    !in_valid_i |=> $stable(tail_i));

  a_r5_valid_after_tick: assert property (@(posedge clk_i) disable iff (!rst_ni)
    tick_i |=> out_valid_o);

  a_r5_capture_pre_update: assert property (@(posedge clk_i) disable iff (!rst_ni)
    tick_i |=> out_data_o == $past(tail_i));

  a_r6_no_stray_valid: assert property (@(posedge clk_i) disable iff (!rst_ni)
    !tick_i |=> !out_valid_o);

  a_r6_out_held: assert property (@(posedge clk_i) disable iff (!rst_ni)
    !tick_i |=> $stable(out_data_o));
endmodule

bind lpf_decim lpf_decim_chk #(.IN_W(IN_W), .GUARD_W(GUARD_W)) u_chk (
  .clk_i      (clk_i),
  .rst_ni     (rst_ni),
  .in_valid_i (in_valid_i),
  .tick_i     (tick_i),
  .out_valid_o(out_valid_o),
  .out_data_o (out_data_o),
  .tail_i     (tail_w)
);

// File: tb/lpf_decim_tb.sv
module lpf_decim_tb;
  localparam int IN_W = 16, GUARD_W = 8, SHIFT = 4, STAGES = 4;
  localparam int W = IN_W + GUARD_W;
  localparam longint HI_IN = (64'sd1 <<< (IN_W-1)) - 1;
  localparam longint LO_IN = -(64'sd1 <<< (IN_W-1));

  logic clk = 1'b0, rst_n = 1'b0;
  logic in_valid = 1'b0, tick = 1'b0;
  logic [IN_W-1:0] in_data = '0;
  logic out_valid;
  logic [W-1:0] out_data;

  int checks = 0, errors = 0;
  longint m [STAGES];
  longint exp_out = 0;
  bit     prev_tick = 1'b0;
  bit     done = 1'b0;

  always #4 clk = ~clk;

  lpf_decim #(.IN_W(IN_W), .GUARD_W(GUARD_W), .SHIFT(SHIFT), .STAGES(STAGES)) u_dut (
    .clk_i(clk), .rst_ni(rst_n), .in_valid_i(in_valid), .in_data_i(in_data),
    .tick_i(tick), .out_valid_o(out_valid), .out_data_o(out_data));

  function automatic longint sx(input logic [W-1:0] v);
    return longint'($signed(v));
  endfunction

  task automatic check(input string tag, input longint act, input longint exp);
    checks++;
    if (act != exp) begin
      errors++;
      $display("FAIL %s: actual %0d expected %0d", tag, act, exp);
    end
  endtask

  // model: all sections update together from pre-update neighbours
  task automatic model_update(input longint x);
    for (int i = STAGES - 1; i >= 0; i--) begin
      longint src = (i == 0) ? (x <<< GUARD_W) : m[i-1];
      m[i] = m[i] + ((src - m[i]) >>> SHIFT);
    end
  endtask

  task automatic step(input string tag, input bit v, input longint x, input bit t);
    @(negedge clk);
    if (prev_tick) begin
      check({tag, " valid"}, longint'(out_valid), 1);
      check({tag, " data"}, sx(out_data), exp_out);
    end else begin
      check("R6 valid low", longint'(out_valid), 0);
      check("R6 data held", sx(out_data), exp_out);
    end
    in_valid = v;
    in_data  = x[IN_W-1:0];
    tick     = t;
    @(posedge clk);
    if (t) exp_out = m[STAGES-1];
    if (v) model_update(x);
    prev_tick = t;
  endtask

  initial begin
    repeat (200000) @(posedge clk);
    if (!done) begin
      errors++;
      $display("FAIL watchdog: actual timeout expected completion");
      $display("Simulation finished: %0d checks, %0d errors", checks, errors);
      $finish;
    end
  end

  initial begin
    void'($urandom(32'd1234));
    for (int i = 0; i < STAGES; i++) m[i] = 0;
    repeat (3) @(negedge clk);
    check("R1 reset valid", longint'(out_valid), 0);
    check("R1 reset data", sx(out_data), 0);
    rst_n = 1'b1;
    step("R1 idle tick", 0, 0, 1);
    step("R1 idle tick", 0, 0, 0);

    // R2: step response to positive full scale
    for (int i = 0; i < 300; i++) step("R2 step", 1, HI_IN, (i % 16) == 15);

    // R3: full-scale swings both ways
    for (int k = 0; k < 6; k++)
      for (int i = 0; i < 120; i++)
        step("R3 swing", 1, (k % 2) ? HI_IN : LO_IN, (i % 8) == 7);
    for (int i = 0; i < 600; i++) step("R3 floor", 1, LO_IN, (i % 32) == 31);
    step("R3 at floor", 0, 0, 1);
    step("R3 at floor", 0, 0, 0);
    check("R3 lower bound", sx(out_data), LO_IN <<< GUARD_W);

    // R4: idle stretches with ticks must repeat the same value
    step("R4 set", 1, 1000, 1);
    for (int i = 0; i < 20; i++) step("R4 idle", 0, longint'($urandom_range(0, 65535)) - 32768, 1);

    // R7: tick and sample every cycle
    for (int i = 0; i < 200; i++)
      step("R7 collide", 1, longint'($urandom_range(0, 65535)) - 32768, 1);

    // R2/R5: random strobes and data
    for (int i = 0; i < 4000; i++) begin
      bit v = ($urandom_range(0, 3) != 0);
      bit t = ($urandom_range(0, 9) == 0);
      longint x = longint'($urandom_range(0, 65535)) - 32768;
      step(t && v ? "R7 random" : "R5 random", v, x, t);
    end
    step("R5 drain", 0, 0, 0);
    step("R6 drain", 0, 0, 0);

    done = 1'b1;
    $display("Simulation finished: %0d checks, %0d errors", checks, errors);
    $finish;
  end
endmodule